// File: doc/BRIEF.md
# Multiframe M-bit Reframe Monitor

This block sits next to a DS3 receive framer and watches the M-bit check result that the framer reports once per received multiframe. It keeps a short history of those results and, when too many of the most recent multiframes carried M-bit errors, asks the framer to give up its current alignment and hunt for F-frame alignment again. The error threshold is selectable, and reframing on M-bit errors can be switched off completely.

The same per-multiframe strobe also drives a far-end block error (FEBE) event selector. When the line runs in C-bit parity mode, the block raises a FEBE event for each multiframe that shows a parity error. A mode bit can widen this so that a framing error in that multiframe also counts. Both results leave the block as single-cycle pulses, and software-visible state is not part of the block.

Top module: `mbit_reframe_mon`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, reframe_req and febe_pulse are 0, and the error history is empty.
- R2: With cfg_thr3 = 0 and cfg_rf_off = 0, a strobe raises reframe_req when at least 2 of the 4 most recent multiframes, counting the one just strobed, have mbit_err = 1.
- R3: With cfg_thr3 = 1 and cfg_rf_off = 0, a strobe raises reframe_req only when at least 3 of those 4 multiframes have mbit_err = 1.
- R4: With cfg_rf_off = 1, reframe_req stays 0. The history still advances on each strobe and is not cleared, so errors seen while reframing is off count toward a request once cfg_rf_off returns to 0.
- R5: A strobe that raises reframe_req empties the history, so later windows count only multiframes that follow it.
- R6: The history advances only on cycles with mf_strobe = 1. The mbit_err value on any other cycle has no effect.
- R7: reframe_req is high for exactly the one cycle that follows the clock edge sampling the qualifying strobe.
- R8: febe_pulse stays 0 whenever cfg_cbit = 0 at the strobe.
- R9: With cfg_cbit = 1, a strobe raises febe_pulse when par_err = 1. With cfg_febe_wide = 1, it also does so when frm_err = 1. With cfg_febe_wide = 0, frm_err is ignored.
- R10: febe_pulse is a one-cycle pulse in the cycle after a qualifying strobe, and the flags on cycles without a strobe never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mf_strobe | input | 1 | One cycle per received multiframe; the flags are valid with it |
| mbit_err | input | 1 | M-bit error seen in this multiframe |
| par_err | input | 1 | Multiframe parity error seen in this multiframe |
| frm_err | input | 1 | Framing error seen in this multiframe |
| cfg_thr3 | input | 1 | 0: reframe at 2 of 4; 1: reframe at 3 of 4 |
| cfg_rf_off | input | 1 | 1 suppresses reframe requests caused by M-bit errors |
| cfg_cbit | input | 1 | 1 when the line runs in C-bit parity mode |
| cfg_febe_wide | input | 1 | 0: FEBE on parity error only; 1: parity or framing error |
| reframe_req | output | 1 | One-cycle request to start a new F-frame search |
| febe_pulse | output | 1 | One-cycle FEBE event |

## Verification
Both outputs come from one register stage. Each is due in the cycle that directly follows the edge that samples the strobe, and it is gone one cycle later. The bench drives each strobe on a falling edge and reads both outputs at the next falling edge. It then holds an idle cycle with scrambled flags and reads the outputs again, so that a late pulse, a stuck pulse or a pulse caused by the flags without a strobe shows up in the check that follows.

// File: rtl/mbrm_pkg.sv
package mbrm_pkg;

  typedef enum logic {
    FEBE_SRC_PARITY  = 1'b0,
    FEBE_SRC_PAR_FRM = 1'b1
  } febe_src_e;

  function automatic logic febe_qualify(input febe_src_e src,
                                        input logic par,
                                        input logic frm);
    logic q;
    q = par;
    if (src == FEBE_SRC_PAR_FRM) q = par | frm;
    return q;
  endfunction

endpackage

// File: rtl/mbrm_window.sv
module mbrm_window #(
  parameter int WIN    = 4,
  parameter int THR_LO = 2,
  parameter int THR_HI = 3,
  localparam int CW    = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          err,
  input  logic          thr_hi,
  input  logic          off,
  output logic          hit,
  output logic [CW-1:0] win_cnt
);

  localparam logic [CW-1:0] TLO = CW'(THR_LO);
  localparam logic [CW-1:0] THI = CW'(THR_HI);

  logic [WIN-1:0] hist_q;
  logic [WIN-1:0] win_next;
  logic [CW-1:0]  thr_sel;

  function automatic logic [CW-1:0] ones(input logic [WIN-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < WIN; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  assign win_next = {hist_q[WIN-2:0], err};
  assign win_cnt  = ones(win_next);
  assign thr_sel  = thr_hi ? THI : TLO;
  assign hit      = stb && !off && (win_cnt >= thr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n)   hist_q <= '0;
    else if (stb) hist_q <= hit ? '0 : win_next;
  end

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(hist_q));

  a_r5_clear_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (hist_q == '0));

  a_r4_keep_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && off) |=> (hist_q[0] == $past(err)));

endmodule

// File: rtl/mbrm_febe.sv
module mbrm_febe
  import mbrm_pkg::*;
(
  input  logic stb,
  input  logic cbit,
  input  logic wide,
  input  logic par,
  input  logic frm,
  output logic hit
);

  febe_src_e src;

  assign src = wide ? FEBE_SRC_PAR_FRM : FEBE_SRC_PARITY;
  assign hit = stb && cbit && febe_qualify(src, par, frm);

endmodule

// File: rtl/mbit_reframe_mon.sv
module mbit_reframe_mon #(
  parameter int WIN    = 4,
  parameter int THR_LO = 2,
  parameter int THR_HI = 3,
  localparam int CW    = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_strobe,
  input  logic mbit_err,
  input  logic par_err,
  input  logic frm_err,
  input  logic cfg_thr3,
  input  logic cfg_rf_off,
  input  logic cfg_cbit,
  input  logic cfg_febe_wide,
  output logic reframe_req,
  output logic febe_pulse
);

  logic          rf_hit;
  logic          fb_hit;
  logic [CW-1:0] win_cnt;

  mbrm_window #(.WIN(WIN), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (mf_strobe),
    .err     (mbit_err),
    .thr_hi  (cfg_thr3),
    .off     (cfg_rf_off),
    .hit     (rf_hit),
    .win_cnt (win_cnt)
  );

  mbrm_febe u_febe (
    .stb  (mf_strobe),
    .cbit (cfg_cbit),
    .wide (cfg_febe_wide),
    .par  (par_err),
    .frm  (frm_err),
    .hit  (fb_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reframe_req <= 1'b0;
      febe_pulse  <= 1'b0;
    end else begin
      reframe_req <= rf_hit;
      febe_pulse  <= fb_hit;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |=> !reframe_req);

  a_r7_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |-> $past(mf_strobe));

  a_r4_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |-> !$past(cfg_rf_off));

  a_r2_low_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |-> ($past(win_cnt) >= CW'(THR_LO)));

  a_r3_high_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (reframe_req && $past(cfg_thr3)) |-> ($past(win_cnt) >= CW'(THR_HI)));

  a_r8_cbit_only: assert property (@(posedge clk) disable iff (!rst_n)
    febe_pulse |-> $past(cfg_cbit));

  a_r9_source: assert property (@(posedge clk) disable iff (!rst_n)
    febe_pulse |-> ($past(par_err) || ($past(cfg_febe_wide) && $past(frm_err))));

  a_r10_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    febe_pulse |-> $past(mf_strobe));

endmodule

// File: tb/mbit_reframe_mon_test.sv
module mbit_reframe_mon_test;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mf_strobe = 1'b0, mbit_err = 1'b0, par_err = 1'b0, frm_err = 1'b0;
  logic cfg_thr3 = 1'b0, cfg_rf_off = 1'b0, cfg_cbit = 1'b0, cfg_febe_wide = 1'b0;
  logic reframe_req, febe_pulse;

  int total = 0;
  int bad = 0;
  logic [7:0] lfsr = 8'hA5;
  int ring [4];   // last four M-bit results, index 0 newest

  always #(PERIOD/2) clk = ~clk;

  mbit_reframe_mon uut (
    .clk(clk), .rst_n(rst_n), .mf_strobe(mf_strobe), .mbit_err(mbit_err),
    .par_err(par_err), .frm_err(frm_err), .cfg_thr3(cfg_thr3),
    .cfg_rf_off(cfg_rf_off), .cfg_cbit(cfg_cbit), .cfg_febe_wide(cfg_febe_wide),
    .reframe_req(reframe_req), .febe_pulse(febe_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  // One multiframe followed by one idle cycle with scrambled flags.
  task automatic one_mf(input logic m, input logic p, input logic f);
    int n;
    logic exp_rf, exp_fb;
    @(negedge clk);
    mf_strobe = 1'b1; mbit_err = m; par_err = p; frm_err = f;
    // shift the bench's own record of recent M-bit results
    for (int i = 3; i > 0; i--) ring[i] = ring[i-1];
    ring[0] = m ? 1 : 0;
    n = ring[0] + ring[1] + ring[2] + ring[3];
    exp_rf = !cfg_rf_off && (n >= (cfg_thr3 ? 3 : 2));
    if (exp_rf) for (int i = 0; i < 4; i++) ring[i] = 0;   // R5 restart
    exp_fb = cfg_cbit && (p || (cfg_febe_wide && f));
    @(negedge clk);
    if (cfg_rf_off)    chk("R4", reframe_req, exp_rf);
    else if (cfg_thr3) chk("R3", reframe_req, exp_rf);
    else               chk("R2", reframe_req, exp_rf);
    if (!cfg_cbit) chk("R8", febe_pulse, exp_fb);
    else           chk("R9", febe_pulse, exp_fb);
    step_lfsr();
    mf_strobe = 1'b0; mbit_err = lfsr[0]; par_err = lfsr[1]; frm_err = lfsr[2];
    @(negedge clk);
    chk("R7", reframe_req, 1'b0);   // R6: idle flags add nothing
    chk("R10", febe_pulse, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) ring[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", reframe_req, 1'b0);
    chk("R1", febe_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", reframe_req, 1'b0);
    chk("R1", febe_pulse, 1'b0);

    // directed: 2-of-4 at the window edge, then restart after a request
    one_mf(1'b1, 1'b0, 1'b0);
    one_mf(1'b0, 1'b0, 1'b0);
    one_mf(1'b0, 1'b0, 1'b0);
    one_mf(1'b1, 1'b0, 1'b0);   // R2: fires, window 1001
    one_mf(1'b1, 1'b0, 1'b0);   // R5: only one since restart
    // R4: errors gathered while off trigger right after re-enable
    cfg_rf_off = 1'b1;
    one_mf(1'b1, 1'b0, 1'b0);
    one_mf(1'b1, 1'b0, 1'b0);
    cfg_rf_off = 1'b0;
    one_mf(1'b0, 1'b0, 1'b0);

    // sweep every configuration with scrambled flags
    for (int c = 0; c < 16; c++) begin
      cfg_thr3      = c[0];
      cfg_rf_off    = c[1];
      cfg_cbit      = c[2];
      cfg_febe_wide = c[3];
      for (int k = 0; k < 48; k++) begin
        step_lfsr();
        one_mf(lfsr[0] | lfsr[3], lfsr[1], lfsr[2]);
      end
    end

    // exhaustive FEBE flag table in both source modes
    for (int c = 0; c < 16; c++) begin
      cfg_cbit = c[0]; cfg_febe_wide = c[1];
      one_mf(1'b0, c[2], c[3]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule